// File: doc/BRIEF.md
# Legacy Printer Port Register Block

This block is the byte-wide register file of a PC-style printer port. A host talks to it over a simple bus with an address, separate read and write strobes, and 8-bit write and read data. Only the three lowest address bits select a register, so the block can sit behind any base-address decoder. Through its registers the host drives a byte onto the printer data lines, sets the control lines, reads the printer status lines and keeps two bytes of scratch storage for enhanced-mode address and data.

The data lines work in one of two directions. With the direction bit of the control register clear, the output latch drives the lines and a data read returns the latch. With the bit set, the drivers are released and a data read returns the lines as sampled through a two-flop synchronizer. The five status inputs pass through the same kind of synchronizer. A falling edge on the synchronized acknowledge line raises a level interrupt, but only while the interrupt enable bit of the control register is set. The interrupt stays high until the host reads the status register.

Top module: `lpt_regblock`

## Requirements
- R1: After reset, the data latch and both enhanced-mode registers hold 0x00, the control register holds 0xC0, `irq` is low and `pd_oe` is high.
- R2: Only `bus_addr[2:0]` selects a register, and higher address bits have no effect. Offset 0 is data, 1 is status, 2 is control, 3 is enhanced address and 4 is enhanced data.
- R3: A write to offset 0 loads the data latch, and `pd_out` shows it from the next cycle. `pd_oe` is high exactly when control bit 5 is clear.
- R4: A read of offset 0 returns the data latch when control bit 5 is clear. When the bit is set, the read returns `pd_in` as seen through two register stages.
- R5: A control write stores `{2'b11, wdata[5:0]}`, and a read of offset 2 returns the stored byte. `ctl_lines` carries control bits 3..0 (bit 3 select, bit 2 reset, bit 1 auto feed, bit 0 strobe). Bit 4 enables the interrupt and bit 5 selects input direction.
- R6: The registers at offsets 3 and 4 read back the last byte written to them.
- R7: Reads of offsets 5, 6 and 7 return 0xFF, and writes to them change no register.
- R8: A status read returns bits 7..3 as `stat_pins[4:0]` after two register stages, where `stat_pins` is busy, ack, paper-out, select, error from bit 4 down to bit 0. Bit 2 is the current `irq`, and bits 1 and 0 read 0.
- R9: A falling edge of the synchronized acknowledge line (`stat_pins[3]`) sets `irq` one cycle after it is seen, and only if control bit 4 is set. The pin-to-`irq` delay is three clock edges.
- R10: `irq` stays high until a status read or reset, and a status read clears it at the next edge. If an acknowledge event and a status read fall in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Host address; only bits 2..0 are decoded |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational in the strobe cycle |
| pd_out | output | 8 | Data line drive value |
| pd_oe | output | 1 | Data line output enable |
| pd_in | input | 8 | Data line sense value |
| stat_pins | input | 5 | Busy, ack, paper-out, select, error (bit 4 down to bit 0) |
| ctl_lines | output | 4 | Select, reset, auto feed, strobe (bit 3 down to bit 0) |
| irq | output | 1 | Level interrupt |

## Verification
The bench works on the acknowledge edge pipeline. It pulses acknowledge with the enable clear and then set, so a design that ignored the enable, or fired on the rising edge, would raise `irq` at the wrong time. It also lines up a status read with the cycle in which an acknowledge event lands, and a design that let the clear win would lose that interrupt. It flips the direction bit while the pins and the latch hold different bytes, writes control bytes whose top bits are zero, and repeats accesses with high address bits set. Each of these exposes a wrong read multiplexer, unforced reserved bits, or a decoder that looks at more than three bits.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int DW = 8;
  localparam int NSTAT = 5;
  localparam int ACK_IDX = 3;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EPPA = 3'd3;
  localparam logic [2:0] OFS_EPPD = 3'd4;
  localparam int CTL_DIR = 5;
  localparam int CTL_IEN = 4;
  localparam logic [DW-1:0] CTRL_RST = 8'hC0;

  // control store: reserved upper bits always read as one
  function automatic logic [DW-1:0] ctrl_store(input logic [DW-1:0] v);
    return {2'b11, v[5:0]};
  endfunction

  // status byte assembly from synchronized pins and interrupt state
  function automatic logic [DW-1:0] stat_byte(input logic [NSTAT-1:0] p, input logic i);
    return {p, i, 2'b00};
  endfunction
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end
  assign q = stg[STAGES-1];
endmodule

// File: rtl/lpt_irq.sv
module lpt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic en,
  input  logic clr,
  output logic evt,
  output logic irq
);
  logic ack_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_prev <= 1'b0;
    else        ack_prev <= ack_s;
  end
  assign evt = ack_prev & ~ack_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         irq <= 1'b0;
    else if (evt && en) irq <= 1'b1;
    else if (clr)       irq <= 1'b0;
  end
endmodule

// File: rtl/lpt_regfile.sv
module lpt_regfile
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        ofs,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     pins_s,
  input  logic [NSTAT-1:0]  stat_s,
  input  logic              irq,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     data_q,
  output logic [DW-1:0]     ctrl_q,
  output logic [DW-1:0]     eppa_q,
  output logic [DW-1:0]     eppd_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= CTRL_RST;
      eppa_q <= '0;
      eppd_q <= '0;
    end else if (wr) begin
      case (ofs)
        OFS_DATA: data_q <= wdata;
        OFS_CTRL: ctrl_q <= ctrl_store(wdata);
        OFS_EPPA: eppa_q <= wdata;
        OFS_EPPD: eppd_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '1;
    if (rd) begin
      case (ofs)
        OFS_DATA: rdata = ctrl_q[CTL_DIR] ? pins_s : data_q;
        OFS_STAT: rdata = stat_byte(stat_s, irq);
        OFS_CTRL: rdata = ctrl_q;
        OFS_EPPA: rdata = eppa_q;
        OFS_EPPD: rdata = eppd_q;
        default:  rdata = '1;
      endcase
    end
  end
endmodule

// File: rtl/lpt_regblock.sv
module lpt_regblock
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  input  logic [7:0]        pd_in,
  input  logic [4:0]        stat_pins,
  output logic [3:0]        ctl_lines,
  output logic              irq
);
  logic [2:0]       ofs;
  logic [DW-1:0]    pins_s, data_q, ctrl_q, eppa_q, eppd_q;
  logic [NSTAT-1:0] stat_s;
  logic             ack_evt, stat_rd;

  assign ofs     = bus_addr[2:0];
  assign stat_rd = bus_rd && (ofs == OFS_STAT);

  lpt_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_dsync (
    .clk(clk), .rst_n(rst_n), .d(pd_in), .q(pins_s));
  lpt_sync #(.W(NSTAT), .STAGES(SYNC_STAGES)) u_ssync (
    .clk(clk), .rst_n(rst_n), .d(stat_pins), .q(stat_s));

  lpt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_s(stat_s[ACK_IDX]), .en(ctrl_q[CTL_IEN]),
    .clr(stat_rd), .evt(ack_evt), .irq(irq));

  lpt_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .ofs(ofs), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .pins_s(pins_s), .stat_s(stat_s), .irq(irq),
    .rdata(bus_rdata), .data_q(data_q), .ctrl_q(ctrl_q),
    .eppa_q(eppa_q), .eppd_q(eppd_q));

  assign pd_out    = data_q;
  assign pd_oe     = ~ctrl_q[CTL_DIR];
  assign ctl_lines = ctrl_q[3:0];
endmodule

// File: rtl/lpt_regblock_chk.sv
module lpt_regblock_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pd_out,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        eppa_q,
  input logic              ack_evt,
  input logic              irq
);
  assert_ctrl_force_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] == 3'd2) |=> ctrl_q == {2'b11, $past(bus_wdata[5:0])});
  assert_data_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] == 3'd0) |=> pd_out == $past(bus_wdata));
  assert_epp_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[2:0] == 3'd3) |=> eppa_q == $past(bus_wdata));
  assert_unused_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2:0] >= 3'd5) |-> bus_rdata == 8'hFF);
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[2:0] == 3'd1 && !ack_evt) |=> !irq);
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ack_evt && ctrl_q[4]));
endmodule

bind lpt_regblock lpt_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .ctrl_q(ctrl_q),
  .eppa_q(eppa_q), .ack_evt(ack_evt), .irq(irq));

// File: tb/test_lpt_regblock.sv
module test_lpt_regblock;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0, pd_in = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [4:0] stat_pins = 5'b01000;
  logic [7:0] bus_rdata, pd_out;
  logic pd_oe, irq;
  logic [3:0] ctl_lines;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  lpt_regblock #(.ADDR_W(8)) i_lpt_regblock (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .stat_pins(stat_pins), .ctl_lines(ctl_lines), .irq(irq));

  // behavioural reference model
  logic [7:0] m_data, m_ctrl, m_eppa, m_eppd, m_d1, m_d2;
  logic [4:0] m_s1, m_s2;
  logic m_prev, m_irq;
  int irq_hits = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_ctrl = 8'hC0; m_eppa = 0; m_eppd = 0;
      m_d1 = 0; m_d2 = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0;
    end else begin
      automatic bit fall = m_prev && !m_s2[3];
      automatic bit srd = bus_rd && bus_addr[2:0] == 1;
      if (fall && m_ctrl[4]) m_irq = 1;
      else if (srd) m_irq = 0;
      m_prev = m_s2[3]; m_s2 = m_s1; m_s1 = stat_pins; m_d2 = m_d1; m_d1 = pd_in;
      if (bus_wr) begin
        unique case (bus_addr[2:0])
          0: m_data = bus_wdata;
          2: m_ctrl = {2'b11, bus_wdata[5:0]};
          3: m_eppa = bus_wdata;
          4: m_eppd = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      0: return m_ctrl[5] ? m_d2 : m_data;
      1: return {m_s2, m_irq, 2'b00};
      2: return m_ctrl;
      3: return m_eppa;
      4: return m_eppd;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the clock edge
  always begin
    @(negedge clk); #(CLK_P/4);
    if (rst_n && !done) begin
      check(pd_out == m_data, "R3 pd_out", pd_out, m_data);
      check(pd_oe == !m_ctrl[5], "R3 pd_oe", {7'd0, pd_oe}, {7'd0, !m_ctrl[5]});
      check(ctl_lines == m_ctrl[3:0], "R5 ctl_lines", {4'd0, ctl_lines}, {4'd0, m_ctrl[3:0]});
      check(irq == m_irq, "R9 R10 irq", {7'd0, irq}, {7'd0, m_irq});
      if (irq) irq_hits++;
      if (bus_rd) begin
        automatic string t;
        case (bus_addr[2:0])
          0: t = "R4 data read"; 1: t = "R8 status read"; 2: t = "R5 ctrl read";
          3, 4: t = "R6 epp read"; default: t = "R7 unused read";
        endcase
        check(bus_rdata == exp_rd(bus_addr[2:0]), t, bus_rdata, exp_rd(bus_addr[2:0]));
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_wr = 0; bus_addr = a;
    #(CLK_P/2 - 1); v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int h0;
    #(CLK_P * 3); rst_n = 1;
    // R1 reset state
    rd(8'h00, v); check(v == 8'h00, "R1 data reset", v, 8'h00);
    rd(8'h02, v); check(v == 8'hC0, "R1 ctrl reset", v, 8'hC0);
    rd(8'h03, v); check(v == 8'h00, "R1 eppa reset", v, 8'h00);
    rd(8'h04, v); check(v == 8'h00, "R1 eppd reset", v, 8'h00);
    check(pd_oe == 1 && irq == 0, "R1 pins reset", {6'd0, pd_oe, irq}, 8'h02);
    // R3/R6 writes and readback
    wr(8'h00, 8'hA5); wr(8'h03, 8'h3C); wr(8'h04, 8'hC3);
    rd(8'h03, v); check(v == 8'h3C, "R6 eppa", v, 8'h3C);
    // R2 high address bits ignored
    wr(8'hF8, 8'h5A); rd(8'h70, v); check(v == 8'h5A, "R2 alias data", v, 8'h5A);
    wr(8'hAB, 8'h11); rd(8'h03, v); check(v == 8'h11, "R2 alias eppa", v, 8'h11);
    // R5 reserved bits forced
    wr(8'h02, 8'h0F); rd(8'h02, v); check(v == 8'hCF, "R5 ctrl force", v, 8'hCF);
    // R7 unused offsets
    for (int a = 5; a < 8; a++) wr(8'(a), 8'h00);
    for (int a = 5; a < 8; a++) begin rd(8'(a), v); check(v == 8'hFF, "R7 unused", v, 8'hFF); end
    rd(8'h00, v); check(v == 8'h5A, "R7 data untouched", v, 8'h5A);
    rd(8'h04, v); check(v == 8'hC3, "R7 eppd untouched", v, 8'hC3);
    // R4 bidirectional
    pd_in = 8'h96; idle(3);
    wr(8'h02, 8'h20); rd(8'h00, v); check(v == 8'h96, "R4 pins read", v, 8'h96);
    wr(8'h02, 8'h00); rd(8'h00, v); check(v == 8'h5A, "R4 latch read", v, 8'h5A);
    // R8 status pins
    stat_pins = 5'b10101; idle(3);
    rd(8'h01, v); check(v == 8'hA8, "R8 status layout", v, 8'hA8);
    // R9 ack with enable clear: no interrupt
    h0 = irq_hits;
    stat_pins = 5'b01000; idle(3); stat_pins = 5'b00000; idle(5);
    check(irq_hits == h0, "R9 gated off", 8'(irq_hits - h0), 8'd0);
    // R9 with enable set
    stat_pins = 5'b01000; wr(8'h02, 8'h10); idle(3);
    stat_pins = 5'b00000; idle(4);
    check(irq == 1, "R9 raised", {7'd0, irq}, 8'd1);
    wr(8'h02, 8'h00); idle(2);
    check(irq == 1, "R10 held", {7'd0, irq}, 8'd1);
    rd(8'h01, v); check(v[2] == 1, "R8 irq bit", v, 8'h04);
    idle(1); check(irq == 0, "R10 cleared", {7'd0, irq}, 8'd0);
    // R10 event and status read in same cycle: event wins
    wr(8'h02, 8'h10); stat_pins = 5'b01000; idle(4);
    @(negedge clk); stat_pins = 5'b00000;
    @(negedge clk); @(negedge clk);
    bus_rd = 1; bus_addr = 8'h01;
    @(negedge clk); bus_rd = 0;
    #(CLK_P/4); check(irq == 1, "R10 event wins", {7'd0, irq}, 8'd1);
    rd(8'h01, v); idle(2);
    check(irq == 0, "R10 final clear", {7'd0, irq}, 8'd0);
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule